// File: doc/BRIEF.md
# Dual-Pool Operand Collector Dispatch

This block holds issued instructions in collector slots while their source operands are gathered from the register banks. It then hands each complete instruction to one of two execution pipelines. The slots are split into two pools. The lower-numbered pool serves the general arithmetic pipeline and the upper pool serves the special-function pipeline. An instruction from the issue register goes into a free slot of the pool that matches its class. The cycle after allocation, the block pulses a read request for that slot so the bank arbiter can fetch the operands. Operand arrivals then retire the slot's outstanding bits one at a time.

Each pool owns a last-in first-out free list, a rotating dispatch pointer and one output pipeline register. The two pools therefore allocate and dispatch independently. A slot is dispatched into its pipeline register only when that register is empty. While the execution side holds the register, that port stalls and the other port keeps moving. Bank arbitration and the execution units lie outside this block.

Top module: `oc_dispatch`

## Requirements
- R1: After reset, both output registers are empty, no read request pulses, and `issueAccept` is low while `issueValid` is low.
- R2: An instruction with `issueIsSfu` high takes a slot from the special-function pool (slots `ALU_SLOTS` to `ALU_SLOTS+SFU_SLOTS-1`). Any other instruction takes a slot from the arithmetic pool (slots 0 to `ALU_SLOTS-1`). A dispatched instruction appears only on its own pool's output.
- R3: When the matching pool has no free slot, `issueAccept` stays low and the instruction is not taken.
- R4: One cycle after an instruction is accepted, `reqPulse` is one-hot on the allocated slot, and `reqUsed` and `reqSrc` carry that instruction's used-operand mask and source fields. Source k lives at bits `[k*REG_W +: REG_W]`.
- R5: A slot is dispatched only after every source operand marked used has arrived. Arrival of operand k for slot s is bit `s*NUM_SRC+k` of `opArrive`, and it takes effect at the clock edge where it is sampled. A slot with no used operands becomes dispatchable one cycle after allocation.
- R6: A port dispatches only into an empty output register. While its hold input is high, the register keeps its contents unchanged. A register released by the execution side is empty for one cycle before the next dispatch. The other port is not affected.
- R7: Among its ready slots, a port picks the first one in ascending circular order that starts just after the slot it last dispatched. After reset, the pointer rests on the pool's highest slot.
- R8: Each free list is last-in first-out. After reset the highest slot of each pool is handed out first. A slot dispatched in a cycle can be allocated again in that same cycle, so a full pool accepts in the cycle one of its slots dispatches.
- R9: Arrival strobes for a free slot or for an operand the slot does not use have no effect.
- R10: At most one slot is allocated per cycle. The two ports may each dispatch one slot in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| issueValid | input | 1 | Issue register holds an instruction |
| issueIsSfu | input | 1 | Instruction belongs to the special-function class |
| issueWarp | input | WARP_W (5) | Warp identifier |
| issueSrc | input | NUM_SRC*REG_W (24) | Source register numbers, operand k at [k*REG_W +: REG_W] |
| issueUsed | input | NUM_SRC (4) | Source operands the instruction reads |
| issueAccept | output | 1 | Instruction taken this cycle |
| opArrive | input | NUM_SLOTS*NUM_SRC (24) | Operand arrival strobes, bit s*NUM_SRC+k |
| aluHold | input | 1 | Arithmetic pipeline keeps its input register |
| sfuHold | input | 1 | Special-function pipeline keeps its input register |
| aluValid | output | 1 | Arithmetic output register full |
| aluWarp | output | WARP_W (5) | Warp in arithmetic output register |
| aluSrc | output | NUM_SRC*REG_W (24) | Sources in arithmetic output register |
| aluSlot | output | 4 | Slot that filled the arithmetic output register |
| sfuValid | output | 1 | Special-function output register full |
| sfuWarp | output | WARP_W (5) | Warp in special-function output register |
| sfuSrc | output | NUM_SRC*REG_W (24) | Sources in special-function output register |
| sfuSlot | output | 4 | Slot that filled the special-function output register |
| reqPulse | output | NUM_SLOTS (6) | One-hot read request for the slot allocated last cycle |
| reqUsed | output | NUM_SRC (4) | Used-operand mask of that request |
| reqSrc | output | NUM_SRC*REG_W (24) | Source numbers of that request |

## Verification
The assertions assume that the issue register follows a valid-until-accepted discipline. They also assume that `opArrive` only marks operands a bank arbiter would actually grant. The stimulus keeps `issueValid` and its fields steady until `issueAccept` is seen. It raises arrival strobes only for one or two chosen cycles. It deliberately includes strobes aimed at free slots and at unused operands so that R9 is exercised. The hold inputs change only on the falling edge, so the scoreboard can tell exactly which clock edge consumes each output.

// File: rtl/oc_pkg.sv
package oc_pkg;
  // Slot index width shared by the control strobes; pools may hold up to 16 slots in total.
  localparam int OC_SLOT_W = 4;
  localparam int PORT_ALU  = 0;
  localparam int PORT_SFU  = 1;

  typedef struct packed {
    logic                       allocEn;
    logic [OC_SLOT_W-1:0]       allocSlot;
    logic [1:0]                 dispEn;
    logic [1:0][OC_SLOT_W-1:0]  dispSlot;
  } ocStrobe_t;
endpackage

// File: rtl/oc_pool.sv
module oc_pool
  import oc_pkg::*;
#(
  parameter int BASE  = 0,
  parameter int COUNT = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [COUNT-1:0]     slotDone,
  input  logic                 portBusy,
  input  logic                 wantAlloc,
  output logic                 dispEn,
  output logic [OC_SLOT_W-1:0] dispSlot,
  output logic                 allocEn,
  output logic [OC_SLOT_W-1:0] allocSlot
);
  localparam int LW = (COUNT > 1) ? $clog2(COUNT) : 1;
  localparam int CW = $clog2(COUNT + 1);

  logic [LW-1:0] lastPtr;
  logic [LW-1:0] freeStack [COUNT];
  logic [CW-1:0] freeCnt;
  logic [LW-1:0] pickLocal;
  logic          pickFound;
  logic [LW-1:0] allocLocal;
  int            topIdx;

  // Rotating search starting just past the last dispatched slot (R7)
  always_comb begin
    pickFound = 1'b0;
    pickLocal = '0;
    for (int n = 0; n < COUNT; n++) begin
      if (!pickFound && slotDone[(int'(lastPtr) + 1 + n) % COUNT]) begin
        pickFound = 1'b1;
        pickLocal = LW'((int'(lastPtr) + 1 + n) % COUNT);
      end
    end
  end

  assign dispEn   = pickFound && !portBusy;
  assign dispSlot = OC_SLOT_W'(BASE) + OC_SLOT_W'(pickLocal);

  // LIFO free list; a slot leaving by dispatch is the freshest entry (R8)
  assign topIdx     = (freeCnt == '0) ? 0 : int'(freeCnt) - 1;
  assign allocEn    = wantAlloc && ((freeCnt != '0) || dispEn);
  assign allocLocal = dispEn ? pickLocal : freeStack[topIdx];
  assign allocSlot  = OC_SLOT_W'(BASE) + OC_SLOT_W'(allocLocal);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastPtr <= LW'(COUNT - 1);
      freeCnt <= CW'(COUNT);
      for (int i = 0; i < COUNT; i++) freeStack[i] <= LW'(i);
    end else begin
      if (dispEn) lastPtr <= pickLocal;
      if (dispEn && !allocEn) begin
        freeStack[int'(freeCnt)] <= pickLocal;
        freeCnt <= freeCnt + 1'b1;
      end else if (allocEn && !dispEn) begin
        freeCnt <= freeCnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/oc_ctrl.sv
module oc_ctrl
  import oc_pkg::*;
#(
  parameter int ALU_SLOTS = 4,
  parameter int SFU_SLOTS = 2,
  localparam int NUM_SLOTS = ALU_SLOTS + SFU_SLOTS
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 issueValid,
  input  logic                 issueIsSfu,
  input  logic [NUM_SLOTS-1:0] slotDone,
  input  logic [1:0]           portBusy,
  output logic                 issueAccept,
  output ocStrobe_t            st
);
  logic [1:0]                poolDisp;
  logic [1:0]                poolAlloc;
  logic [1:0][OC_SLOT_W-1:0] poolDispSlot;
  logic [1:0][OC_SLOT_W-1:0] poolAllocSlot;

  for (genvar p = 0; p < 2; p++) begin : gPool
    localparam int BASE  = (p == PORT_ALU) ? 0 : ALU_SLOTS;
    localparam int COUNT = (p == PORT_ALU) ? ALU_SLOTS : SFU_SLOTS;
    logic wantAlloc;
    // Class routing (R2)
    assign wantAlloc = issueValid && ((p == PORT_SFU) ? issueIsSfu : !issueIsSfu);

    oc_pool #(.BASE(BASE), .COUNT(COUNT)) u_pool (
      .clk       (clk),
      .rstN      (rstN),
      .slotDone  (slotDone[BASE +: COUNT]),
      .portBusy  (portBusy[p]),
      .wantAlloc (wantAlloc),
      .dispEn    (poolDisp[p]),
      .dispSlot  (poolDispSlot[p]),
      .allocEn   (poolAlloc[p]),
      .allocSlot (poolAllocSlot[p])
    );
  end

  assign issueAccept  = |poolAlloc;
  assign st.allocEn   = |poolAlloc;
  assign st.allocSlot = poolAlloc[PORT_SFU] ? poolAllocSlot[PORT_SFU] : poolAllocSlot[PORT_ALU];
  assign st.dispEn    = poolDisp;
  assign st.dispSlot  = poolDispSlot;
endmodule

// File: rtl/oc_data.sv
module oc_data
  import oc_pkg::*;
#(
  parameter int NUM_SLOTS = 6,
  parameter int NUM_SRC   = 4,
  parameter int REG_W     = 6,
  parameter int WARP_W    = 5,
  localparam int SRC_W    = NUM_SRC * REG_W
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  ocStrobe_t                    st,
  input  logic [WARP_W-1:0]            issueWarp,
  input  logic [SRC_W-1:0]             issueSrc,
  input  logic [NUM_SRC-1:0]           issueUsed,
  input  logic [NUM_SLOTS*NUM_SRC-1:0] opArrive,
  input  logic [1:0]                   portHold,
  output logic [NUM_SLOTS-1:0]         slotDone,
  output logic [1:0]                   portValid,
  output logic [1:0][WARP_W-1:0]       portWarp,
  output logic [1:0][SRC_W-1:0]        portSrc,
  output logic [1:0][OC_SLOT_W-1:0]    portSlot,
  output logic [NUM_SLOTS-1:0]         reqPulse,
  output logic [NUM_SRC-1:0]           reqUsed,
  output logic [SRC_W-1:0]             reqSrc
);
  logic [NUM_SLOTS-1:0]              slotValid;
  logic [NUM_SLOTS-1:0][WARP_W-1:0]  slotWarp;
  logic [NUM_SLOTS-1:0][SRC_W-1:0]   slotSrc;
  logic [NUM_SLOTS-1:0][NUM_SRC-1:0] slotPend;
  logic [NUM_SLOTS-1:0]              dispHit;
  logic [NUM_SLOTS-1:0]              allocHit;

  always_comb begin
    for (int i = 0; i < NUM_SLOTS; i++) begin
      dispHit[i]  = (st.dispEn[PORT_ALU] && st.dispSlot[PORT_ALU] == OC_SLOT_W'(i)) ||
                    (st.dispEn[PORT_SFU] && st.dispSlot[PORT_SFU] == OC_SLOT_W'(i));
      allocHit[i] = st.allocEn && st.allocSlot == OC_SLOT_W'(i);
      slotDone[i] = slotValid[i] && (slotPend[i] == '0);
    end
  end

  // Slot state: dispatch frees, allocation (after dispatch) refills, arrivals retire last (R5, R9)
  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotValid <= '0;
      slotWarp  <= '0;
      slotSrc   <= '0;
      slotPend  <= '0;
    end else begin
      for (int i = 0; i < NUM_SLOTS; i++) begin
        if (allocHit[i]) begin
          slotValid[i] <= 1'b1;
          slotWarp[i]  <= issueWarp;
          slotSrc[i]   <= issueSrc;
          slotPend[i]  <= issueUsed;
        end else if (dispHit[i]) begin
          slotValid[i] <= 1'b0;
          slotPend[i]  <= '0;
        end else if (slotValid[i]) begin
          slotPend[i]  <= slotPend[i] & ~opArrive[i*NUM_SRC +: NUM_SRC];
        end
      end
    end
  end

  // Output pipeline registers, one per port (R6)
  for (genvar p = 0; p < 2; p++) begin : gOut
    always_ff @(posedge clk) begin
      if (!rstN) begin
        portValid[p] <= 1'b0;
        portWarp[p]  <= '0;
        portSrc[p]   <= '0;
        portSlot[p]  <= '0;
      end else if (st.dispEn[p]) begin
        portValid[p] <= 1'b1;
        portWarp[p]  <= slotWarp[st.dispSlot[p]];
        portSrc[p]   <= slotSrc[st.dispSlot[p]];
        portSlot[p]  <= st.dispSlot[p];
      end else if (portValid[p] && !portHold[p]) begin
        portValid[p] <= 1'b0;
      end
    end
  end

  // Read request for the slot allocated in the previous cycle (R4)
  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqPulse <= '0;
      reqUsed  <= '0;
      reqSrc   <= '0;
    end else if (st.allocEn) begin
      reqPulse <= NUM_SLOTS'(1) << st.allocSlot;
      reqUsed  <= issueUsed;
      reqSrc   <= issueSrc;
    end else begin
      reqPulse <= '0;
      reqUsed  <= '0;
    end
  end
endmodule

// File: rtl/oc_dispatch.sv
module oc_dispatch
  import oc_pkg::*;
#(
  parameter int ALU_SLOTS = 4,
  parameter int SFU_SLOTS = 2,
  parameter int NUM_SRC   = 4,
  parameter int REG_W     = 6,
  parameter int WARP_W    = 5,
  localparam int NUM_SLOTS = ALU_SLOTS + SFU_SLOTS,
  localparam int SRC_W     = NUM_SRC * REG_W
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         issueValid,
  input  logic                         issueIsSfu,
  input  logic [WARP_W-1:0]            issueWarp,
  input  logic [SRC_W-1:0]             issueSrc,
  input  logic [NUM_SRC-1:0]           issueUsed,
  output logic                         issueAccept,
  input  logic [NUM_SLOTS*NUM_SRC-1:0] opArrive,
  input  logic                         aluHold,
  input  logic                         sfuHold,
  output logic                         aluValid,
  output logic [WARP_W-1:0]            aluWarp,
  output logic [SRC_W-1:0]             aluSrc,
  output logic [OC_SLOT_W-1:0]         aluSlot,
  output logic                         sfuValid,
  output logic [WARP_W-1:0]            sfuWarp,
  output logic [SRC_W-1:0]             sfuSrc,
  output logic [OC_SLOT_W-1:0]         sfuSlot,
  output logic [NUM_SLOTS-1:0]         reqPulse,
  output logic [NUM_SRC-1:0]           reqUsed,
  output logic [SRC_W-1:0]             reqSrc
);
  ocStrobe_t                 st;
  logic [NUM_SLOTS-1:0]      slotDone;
  logic [1:0]                portValid;
  logic [1:0][WARP_W-1:0]    portWarp;
  logic [1:0][SRC_W-1:0]     portSrc;
  logic [1:0][OC_SLOT_W-1:0] portSlot;

  oc_ctrl #(.ALU_SLOTS(ALU_SLOTS), .SFU_SLOTS(SFU_SLOTS)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .issueValid  (issueValid),
    .issueIsSfu  (issueIsSfu),
    .slotDone    (slotDone),
    .portBusy    (portValid),
    .issueAccept (issueAccept),
    .st          (st)
  );

  oc_data #(.NUM_SLOTS(NUM_SLOTS), .NUM_SRC(NUM_SRC), .REG_W(REG_W), .WARP_W(WARP_W)) u_data (
    .clk       (clk),
    .rstN      (rstN),
    .st        (st),
    .issueWarp (issueWarp),
    .issueSrc  (issueSrc),
    .issueUsed (issueUsed),
    .opArrive  (opArrive),
    .portHold  ({sfuHold, aluHold}),
    .slotDone  (slotDone),
    .portValid (portValid),
    .portWarp  (portWarp),
    .portSrc   (portSrc),
    .portSlot  (portSlot),
    .reqPulse  (reqPulse),
    .reqUsed   (reqUsed),
    .reqSrc    (reqSrc)
  );

  assign aluValid = portValid[PORT_ALU];
  assign aluWarp  = portWarp[PORT_ALU];
  assign aluSrc   = portSrc[PORT_ALU];
  assign aluSlot  = portSlot[PORT_ALU];
  assign sfuValid = portValid[PORT_SFU];
  assign sfuWarp  = portWarp[PORT_SFU];
  assign sfuSrc   = portSrc[PORT_SFU];
  assign sfuSlot  = portSlot[PORT_SFU];
endmodule

// File: rtl/oc_dispatch_chk.sv
module oc_dispatch_chk
  import oc_pkg::*;
#(
  parameter int ALU_SLOTS = 4,
  parameter int NUM_SLOTS = 6,
  parameter int WARP_W    = 5
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 issueValid,
  input logic                 issueAccept,
  input logic                 aluHold,
  input logic                 sfuHold,
  input logic                 aluValid,
  input logic [WARP_W-1:0]    aluWarp,
  input logic [OC_SLOT_W-1:0] aluSlot,
  input logic                 sfuValid,
  input logic [WARP_W-1:0]    sfuWarp,
  input logic [OC_SLOT_W-1:0] sfuSlot,
  input logic [NUM_SLOTS-1:0] reqPulse
);
  // R3
  accept_needs_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    issueAccept |-> issueValid);

  // R4
  req_follows_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqPulse != '0) |-> $past(issueAccept));

  // R10
  req_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(reqPulse));

  // R2
  alu_pool_slot_chk: assert property (@(posedge clk) disable iff (!rstN)
    aluValid |-> (int'(aluSlot) < ALU_SLOTS));

  // R2
  sfu_pool_slot_chk: assert property (@(posedge clk) disable iff (!rstN)
    sfuValid |-> (int'(sfuSlot) >= ALU_SLOTS && int'(sfuSlot) < NUM_SLOTS));

  // R6
  alu_hold_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (aluValid && aluHold) |=> (aluValid && $stable(aluWarp) && $stable(aluSlot)));

  // R6
  sfu_hold_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sfuValid && sfuHold) |=> (sfuValid && $stable(sfuWarp) && $stable(sfuSlot)));

  // R6
  alu_drain_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (aluValid && !aluHold) |=> !aluValid);

  // R6
  sfu_drain_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sfuValid && !sfuHold) |=> !sfuValid);
endmodule

bind oc_dispatch oc_dispatch_chk #(
  .ALU_SLOTS (ALU_SLOTS),
  .NUM_SLOTS (NUM_SLOTS),
  .WARP_W    (WARP_W)
) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .issueValid  (issueValid),
  .issueAccept (issueAccept),
  .aluHold     (aluHold),
  .sfuHold     (sfuHold),
  .aluValid    (aluValid),
  .aluWarp     (aluWarp),
  .aluSlot     (aluSlot),
  .sfuValid    (sfuValid),
  .sfuWarp     (sfuWarp),
  .sfuSlot     (sfuSlot),
  .reqPulse    (reqPulse)
);

// File: tb/oc_dispatch_tb.sv
module oc_dispatch_tb;
  localparam int NSLOT = 6;
  localparam int NSRC  = 4;
  localparam int RW    = 6;
  localparam int WW    = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic issueValid = 1'b0, issueIsSfu = 1'b0;
  logic [WW-1:0] issueWarp = '0;
  logic [NSRC*RW-1:0] issueSrc = '0;
  logic [NSRC-1:0] issueUsed = '0;
  logic issueAccept;
  logic [NSLOT*NSRC-1:0] opArrive = '0;
  logic aluHold = 1'b0, sfuHold = 1'b0;
  logic aluValid, sfuValid;
  logic [WW-1:0] aluWarp, sfuWarp;
  logic [NSRC*RW-1:0] aluSrc, sfuSrc, reqSrc;
  logic [3:0] aluSlot, sfuSlot;
  logic [NSLOT-1:0] reqPulse;
  logic [NSRC-1:0] reqUsed;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [8:0] aluQ[$];
  logic [8:0] sfuQ[$];

  always #5 clk = ~clk;

  oc_dispatch u_dut (
    .clk(clk), .rstN(rstN), .issueValid(issueValid), .issueIsSfu(issueIsSfu),
    .issueWarp(issueWarp), .issueSrc(issueSrc), .issueUsed(issueUsed),
    .issueAccept(issueAccept), .opArrive(opArrive), .aluHold(aluHold), .sfuHold(sfuHold),
    .aluValid(aluValid), .aluWarp(aluWarp), .aluSrc(aluSrc), .aluSlot(aluSlot),
    .sfuValid(sfuValid), .sfuWarp(sfuWarp), .sfuSrc(sfuSrc), .sfuSlot(sfuSlot),
    .reqPulse(reqPulse), .reqUsed(reqUsed), .reqSrc(reqSrc)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [NSLOT*NSRC-1:0] arr(input int slot, input int op);
    return (NSLOT*NSRC)'(1) << (slot*NSRC + op);
  endfunction

  function automatic logic [NSRC*RW-1:0] srcOf(input int w);
    return {RW'(w+3), RW'(w+2), RW'(w+1), RW'(w)};
  endfunction

  task automatic expectAlu(input int w, input int s);
    aluQ.push_back({WW'(w), 4'(s)});
  endtask

  task automatic expectSfu(input int w, input int s);
    sfuQ.push_back({WW'(w), 4'(s)});
  endtask

  // Driver: called at a falling edge; waits for acceptance, then checks the request pulse
  task automatic issueWait(input bit sfu, input int w, input logic [NSRC-1:0] used, input int expSlot);
    issueValid = 1'b1; issueIsSfu = sfu; issueWarp = WW'(w);
    issueUsed = used; issueSrc = srcOf(w);
    #1;
    while (!issueAccept) begin
      @(negedge clk); #1;
    end
    @(posedge clk);
    @(negedge clk);
    issueValid = 1'b0;
    #1;
    check(reqPulse == NSLOT'(1) << expSlot, "R2/R8 slot choice via reqPulse", int'(reqPulse), 1 << expSlot);
    check(reqUsed == used && reqSrc == srcOf(w), "R4 request fields", int'(reqUsed), int'(used));
  endtask

  task automatic arrive(input logic [NSLOT*NSRC-1:0] m);
    opArrive = m;
    @(negedge clk);
    opArrive = '0;
  endtask

  // Monitor: an item is retired on the edge where its register is released
  initial begin
    forever begin
      @(negedge clk); #1;
      if (rstN && aluValid && !aluHold) begin
        if (aluQ.size() == 0) check(0, "R7 unexpected alu dispatch", int'(aluWarp), -1);
        else begin
          automatic logic [8:0] e = aluQ.pop_front();
          check({aluWarp, aluSlot} == e, "R7 alu order warp/slot", int'({aluWarp, aluSlot}), int'(e));
        end
      end
      if (rstN && sfuValid && !sfuHold) begin
        if (sfuQ.size() == 0) check(0, "R7 unexpected sfu dispatch", int'(sfuWarp), -1);
        else begin
          automatic logic [8:0] e = sfuQ.pop_front();
          check({sfuWarp, sfuSlot} == e, "R7 sfu order warp/slot", int'({sfuWarp, sfuSlot}), int'(e));
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1 reset state
    check(!aluValid, "R1 alu empty", int'(aluValid), 0);
    check(!sfuValid, "R1 sfu empty", int'(sfuValid), 0);
    check(reqPulse == '0, "R1 no request", int'(reqPulse), 0);
    check(!issueAccept, "R1 no accept", int'(issueAccept), 0);
    @(negedge clk);

    // R2 routing, R10 parallel dispatch
    issueWait(0, 1, 4'b0011, 3); expectAlu(1, 3);
    issueWait(1, 2, 4'b0001, 5); expectSfu(2, 5);
    arrive(arr(3,0) | arr(3,1) | arr(5,0));
    #1;
    check(!aluValid && !sfuValid, "R5 not yet dispatched", int'(aluValid), 0);
    @(negedge clk); #1;
    check(aluValid && sfuValid, "R10 both ports same cycle", int'({aluValid, sfuValid}), 3);
    @(negedge clk);

    // R5 partial arrival, R8 LIFO reuse of slot 3
    issueWait(0, 3, 4'b1111, 3);
    arrive(arr(3,0) | arr(3,1) | arr(3,2));
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); #1;
      check(!aluValid, "R5 waits for last operand", int'(aluValid), 0);
    end
    @(negedge clk);
    expectAlu(3, 3);
    arrive(arr(3,3));
    repeat (3) @(negedge clk);

    // R6 hold on ALU, SFU unaffected; R7 rotation on release
    aluHold = 1'b1;
    expectAlu(4, 3); expectAlu(7, 2); expectAlu(5, 3);
    issueWait(0, 4, 4'b0000, 3);
    @(negedge clk); #1;
    check(aluValid && aluWarp == 5'd4, "R6 dispatch into empty register", int'(aluWarp), 4);
    issueWait(0, 5, 4'b0000, 3);
    expectSfu(6, 5);
    issueWait(1, 6, 4'b0000, 5);
    @(negedge clk); #1;
    check(sfuValid && sfuWarp == 5'd6, "R6 other port unaffected", int'(sfuWarp), 6);
    issueWait(0, 7, 4'b0000, 2);
    for (int k = 0; k < 2; k++) begin
      @(negedge clk); #1;
      check(aluValid && aluWarp == 5'd4 && aluSlot == 4'd3, "R6 held register stable", int'(aluWarp), 4);
    end
    @(negedge clk);
    aluHold = 1'b0;
    repeat (8) @(negedge clk);

    // R3 full SFU pool, R8 same-cycle reuse
    expectSfu(8, 5); expectSfu(9, 4); expectSfu(10, 5);
    issueWait(1, 8, 4'b0001, 5);
    issueWait(1, 9, 4'b0001, 4);
    issueValid = 1'b1; issueIsSfu = 1'b1; issueWarp = 5'd10; issueUsed = 4'b0001; issueSrc = srcOf(10);
    #1;
    check(!issueAccept, "R3 full pool refuses", int'(issueAccept), 0);
    @(negedge clk); #1;
    check(!issueAccept, "R3 still refused", int'(issueAccept), 0);
    @(negedge clk);
    arrive(arr(5,0));
    #1;
    check(issueAccept, "R8 accept in dispatch cycle", int'(issueAccept), 1);
    issueWait(1, 10, 4'b0001, 5);
    arrive(arr(4,0) | arr(5,0));
    repeat (6) @(negedge clk);

    // R9 arrivals to free slots and unused operands ignored
    issueWait(0, 11, 4'b0001, 3);
    arrive(arr(3,1) | arr(2,0));
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); #1;
      check(!aluValid, "R9 unused operand ignored", int'(aluValid), 0);
    end
    @(negedge clk);
    issueWait(0, 12, 4'b0001, 2);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); #1;
      check(!aluValid, "R9 free-slot arrival ignored", int'(aluValid), 0);
    end
    @(negedge clk);
    expectAlu(12, 2); expectAlu(11, 3);
    arrive(arr(3,0) | arr(2,0));
    repeat (8) @(negedge clk);

    check(aluQ.size() == 0, "R7 all alu items seen", aluQ.size(), 0);
    check(sfuQ.size() == 0, "R7 all sfu items seen", sfuQ.size(), 0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule